// File: doc/BRIEF.md
# Power and Sleep Controller

This block gates the clock and the reset of a set of peripheral modules that are grouped into power domains. Software programs it through a 32-bit register port with word-aligned addresses. Each module has a control word that holds a requested state, an active-low local reset bit and a force bit. The requested state is not acted on when it is written. It is only picked up when software writes a per-domain transition command, called GO below.

A GO starts that domain's transition engine. If the domain is powered off and its control word asks for power, the engine first raises an external power request. It then waits for software to report power-good through the domain control word. Once power-good is seen, a fixed number of cycles pass before every module of the domain moves to its requested state at once, and the busy bit drops. Module `m` belongs to domain `m % N_DOM`.

The register port is a plain single-beat bus with no back-pressure: an access is taken on every clock edge where `reg_en` is high. Read data is registered and appears one cycle after the read. Status and gating pins are plain levels.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, every module is in state 0 with its clock enable low and its reset output low. Every domain reads powered off with NEXT=1 and power-good=0. No busy bit and no power request is set.
- R2: The register offsets are as follows. Power request status is at 0x070, GO command at 0x120, busy status at 0x128. Domain status is at 0x200+4n and domain control at 0x300+4n. Module status is at 0x800+4n and module control at 0xA00+4n. Read data appears on `reg_rdata` one cycle after the read.
- R3: Module control bits 5:0 hold the requested state: 0 is reset with clock off, 1 is sync reset, 2 is clock gated out of reset, 3 is running. Bit 8 is the active-low local reset and bit 31 is the force bit. All three read back as written.
- R4: Rewriting a module's requested state without a GO leaves its status word, clock enable and reset output unchanged.
- R5: Writing 1 to bit n of the GO register sets bit n of the busy register. On a domain that needs no power-up, busy stays set for exactly LAT cycles.
- R6: A GO written to a domain that is already busy is ignored and does not lengthen the transition.
- R7: Consider a GO to a domain that is off with NEXT (domain control bit 0) set. It raises bit n of the power request register and holds busy until domain control bit 8 (power-good) reads 1. One cycle later the request drops, the domain status reads 1, the power-good bit clears and the LAT count starts.
- R8: When a transition finishes, every module of that domain takes its requested state into status bits 5:0. Modules of other domains keep theirs.
- R9: Module status bit 12 and the module clock enable pin are 1 exactly when the module state is 3.
- R10: The module reset pin is high only when the state is 2 or 3 and the local reset bit is 1. A change of the local reset bit reaches the pin on the write edge, with no GO.
- R11: A GO on a domain whose NEXT bit is 0 runs with no power request and leaves the domain status at 0.
- R12: Reads of unmapped offsets, of the GO register, and of slots beyond the domain or module count return 0. Writes to status registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe, one access per cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after a read |
| mod_clk_en | output | N_MOD | Per-module clock enable |
| mod_rst_n | output | N_MOD | Per-module active-low reset |
| dom_pwr_req | output | N_DOM | Per-domain external power request |

## Verification
A write takes effect on the edge that samples it. A read returns the state just before its own edge, so the bench counts edges from the stimulus to the read. After a GO on a powered domain, the read LAT edges later must still show busy and the next read must show it clear. With a power-up, both of those reads shift by LAT+1 and LAT+2 edges after the power-good write. Clock-enable and reset pins are sampled one time unit after the edge that updates them.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 6;

  typedef enum logic [5:0] {
    MS_OFF     = 6'd0,
    MS_SYNCRST = 6'd1,
    MS_GATED   = 6'd2,
    MS_RUN     = 6'd3
  } mod_state_e;

  typedef enum logic [1:0] {
    DE_IDLE,
    DE_WAIT_PG,
    DE_COUNT
  } dom_eng_e;

  localparam logic [ADDR_W-1:0] A_PWRREQ = 12'h070;
  localparam logic [ADDR_W-1:0] A_GO     = 12'h120;
  localparam logic [ADDR_W-1:0] A_BUSY   = 12'h128;
  localparam logic [3:0] PG_DSTAT = 4'h2;
  localparam logic [3:0] PG_DCTL  = 4'h3;
  localparam logic [3:0] PG_MSTAT = 4'h8;
  localparam logic [3:0] PG_MCTL  = 4'hA;

  localparam int B_LRST  = 8;
  localparam int B_FORCE = 31;
  localparam int B_CLKON = 12;
  localparam int B_NEXT  = 0;
  localparam int B_PGOOD = 8;
endpackage

// File: rtl/psc_dom_engine.sv
module psc_dom_engine
  import psc_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic next_on,
  input  logic pg_ok,
  output logic busy,
  output logic pwr_req,
  output logic dom_on,
  output logic pg_take,
  output logic apply
);
  localparam int CW = $clog2(LAT + 1);

  dom_eng_e      st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= DE_IDLE;
      cnt    <= '0;
      dom_on <= 1'b0;
    end else begin
      case (st)
        DE_IDLE: if (go) begin
          if (!dom_on && next_on) begin
            st <= DE_WAIT_PG;
          end else begin
            st  <= DE_COUNT;
            cnt <= CW'(LAT - 1);
          end
        end
        DE_WAIT_PG: if (pg_ok) begin
          st     <= DE_COUNT;
          cnt    <= CW'(LAT - 1);
          dom_on <= 1'b1;
        end
        DE_COUNT: begin
          if (cnt == '0) begin
            st     <= DE_IDLE;
            dom_on <= next_on;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= DE_IDLE;
      endcase
    end
  end

  assign busy    = (st != DE_IDLE);
  assign pwr_req = (st == DE_WAIT_PG);
  assign pg_take = (st == DE_WAIT_PG) && pg_ok;
  assign apply   = (st == DE_COUNT) && (cnt == '0);
endmodule

// File: rtl/psc_mod_unit.sv
module psc_mod_unit
  import psc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wd,
  input  logic        apply,
  output logic [31:0] ctl_rd,
  output logic [31:0] st_rd,
  output logic        clk_en,
  output logic        rst_out_n
);
  logic [5:0] req_st;
  logic [5:0] cur_st;
  logic       lrst_bit;
  logic       force_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_st    <= MS_OFF;
      lrst_bit  <= 1'b1;
      force_bit <= 1'b0;
    end else if (ctl_we) begin
      req_st    <= ctl_wd[5:0];
      lrst_bit  <= ctl_wd[B_LRST];
      force_bit <= ctl_wd[B_FORCE];
    end
  end

  // The requested state moves into the live state only on the domain's apply pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_st <= MS_OFF;
    else if (apply) cur_st <= req_st;
  end

  assign clk_en    = (cur_st == MS_RUN);
  assign rst_out_n = lrst_bit && ((cur_st == MS_RUN) || (cur_st == MS_GATED));

  always_comb begin
    ctl_rd          = '0;
    ctl_rd[5:0]     = req_st;
    ctl_rd[B_LRST]  = lrst_bit;
    ctl_rd[B_FORCE] = force_bit;
    st_rd           = '0;
    st_rd[5:0]      = cur_st;
    st_rd[B_CLKON]  = clk_en;
  end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import psc_pkg::*;
#(
  parameter int N_MOD = 4,
  parameter int N_DOM = 2,
  parameter int LAT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [N_MOD-1:0]  mod_clk_en,
  output logic [N_MOD-1:0]  mod_rst_n,
  output logic [N_DOM-1:0]  dom_pwr_req
);
  logic             wr_acc;
  logic             aligned;
  logic [3:0]       page;
  logic [IDX_W-1:0] idx;

  assign wr_acc  = reg_en && reg_wr;
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign page    = reg_addr[11:8];
  assign idx     = reg_addr[7:2];

  logic [N_DOM-1:0] dom_busy, dom_on, dom_apply, dom_pg_take, dom_go;
  logic [N_DOM-1:0] dc_next, dc_good;
  logic [31:0]      mctl_rd [N_MOD];
  logic [31:0]      mst_rd  [N_MOD];

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    logic dc_we;
    assign dc_we     = wr_acc && aligned && (page == PG_DCTL) && (idx == IDX_W'(d));
    assign dom_go[d] = wr_acc && (reg_addr == A_GO) && reg_wdata[d] && !dom_busy[d];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dc_next[d] <= 1'b1;
        dc_good[d] <= 1'b0;
      end else if (dc_we) begin
        dc_next[d] <= reg_wdata[B_NEXT];
        dc_good[d] <= reg_wdata[B_PGOOD];
      end else if (dom_pg_take[d]) begin
        dc_good[d] <= 1'b0;
      end
    end

    psc_dom_engine #(.LAT(LAT)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (dom_go[d]),
      .next_on (dc_next[d]),
      .pg_ok   (dc_good[d]),
      .busy    (dom_busy[d]),
      .pwr_req (dom_pwr_req[d]),
      .dom_on  (dom_on[d]),
      .pg_take (dom_pg_take[d]),
      .apply   (dom_apply[d])
    );
  end

  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    logic mc_we;
    assign mc_we = wr_acc && aligned && (page == PG_MCTL) && (idx == IDX_W'(m));

    psc_mod_unit u_mod (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (mc_we),
      .ctl_wd    (reg_wdata),
      .apply     (dom_apply[m % N_DOM]),
      .ctl_rd    (mctl_rd[m]),
      .st_rd     (mst_rd[m]),
      .clk_en    (mod_clk_en[m]),
      .rst_out_n (mod_rst_n[m])
    );
  end

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (aligned) begin
      if (reg_addr == A_PWRREQ) rd_next[N_DOM-1:0] = dom_pwr_req;
      if (reg_addr == A_BUSY)   rd_next[N_DOM-1:0] = dom_busy;
      for (int d = 0; d < N_DOM; d++) begin
        if (page == PG_DSTAT && idx == IDX_W'(d)) rd_next[0] = dom_on[d];
        if (page == PG_DCTL && idx == IDX_W'(d)) begin
          rd_next[B_NEXT]  = dc_next[d];
          rd_next[B_PGOOD] = dc_good[d];
        end
      end
      for (int m = 0; m < N_MOD; m++) begin
        if (page == PG_MSTAT && idx == IDX_W'(m)) rd_next = mst_rd[m];
        if (page == PG_MCTL  && idx == IDX_W'(m)) rd_next = mctl_rd[m];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_en && !reg_wr) reg_rdata <= rd_next;
  end
endmodule

// File: rtl/pwr_sleep_ctrl_sva.sv
module pwr_sleep_ctrl_sva #(
  parameter int N_MOD = 4,
  parameter int N_DOM = 2,
  parameter int LAT   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_en,
  input logic             reg_wr,
  input logic [11:0]      reg_addr,
  input logic [N_DOM-1:0] cmd_bits,
  input logic [31:0]      reg_rdata,
  input logic [N_MOD-1:0] mod_clk_en,
  input logic [N_DOM-1:0] dom_pwr_req,
  input logic [N_DOM-1:0] dom_busy
);
  for (genvar d = 0; d < N_DOM; d++) begin : g_d
    logic [15:0] run_len;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_len <= '0;
      else if (dom_busy[d]) run_len <= (run_len == 16'hFFFF) ? run_len : run_len + 1'b1;
      else run_len <= '0;
    end

    p_req_inside_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dom_pwr_req[d] |-> dom_busy[d]);

    p_busy_from_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_busy[d]) |-> $past(reg_en && reg_wr && reg_addr == 12'h120 && cmd_bits[d]));

    p_busy_min_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dom_busy[d]) |-> (run_len >= 16'(LAT)));
  end

  for (genvar m = 0; m < N_MOD; m++) begin : g_m
    p_clk_moves_with_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mod_clk_en[m]) |-> $past(dom_busy[m % N_DOM]));
  end

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_en && !reg_wr && reg_addr == 12'h004) |-> (reg_rdata == 32'h0));
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_sva #(.N_MOD(N_MOD), .N_DOM(N_DOM), .LAT(LAT)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_en      (reg_en),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .cmd_bits    (reg_wdata[N_DOM-1:0]),
  .reg_rdata   (reg_rdata),
  .mod_clk_en  (mod_clk_en),
  .dom_pwr_req (dom_pwr_req),
  .dom_busy    (dom_busy)
);

// File: tb/tb_pwr_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_sleep_ctrl;
  localparam int N_MOD = 4;
  localparam int N_DOM = 2;
  localparam int LAT   = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_en = 1'b0, reg_wr = 1'b0;
  logic [11:0]      reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [N_MOD-1:0] mod_clk_en, mod_rst_n;
  logic [N_DOM-1:0] dom_pwr_req;

  always #2.5 clk = ~clk;

  pwr_sleep_ctrl #(.N_MOD(N_MOD), .N_DOM(N_DOM), .LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n), .dom_pwr_req(dom_pwr_req)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [5:0] req_st [N_MOD];
  logic [5:0] cur_st [N_MOD];
  logic       lrst   [N_MOD];
  logic       frc    [N_MOD];
  logic       on_m   [N_DOM];
  logic       next_m [N_DOM];

  function automatic logic [11:0] a_dstat(int n); return 12'h200 + 12'(4*n); endfunction
  function automatic logic [11:0] a_dctl(int n);  return 12'h300 + 12'(4*n); endfunction
  function automatic logic [11:0] a_mstat(int n); return 12'h800 + 12'(4*n); endfunction
  function automatic logic [11:0] a_mctl(int n);  return 12'hA00 + 12'(4*n); endfunction

  function automatic logic [31:0] f_mstat(logic [5:0] s);
    logic [31:0] r = '0;
    r[5:0] = s;
    r[12]  = (s == 6'd3);
    return r;
  endfunction
  function automatic logic [31:0] f_mctl(logic [5:0] s, logic l, logic f);
    logic [31:0] r = '0;
    r[5:0] = s; r[8] = l; r[31] = f;
    return r;
  endfunction
  function automatic logic f_rstn(logic [5:0] s, logic l);
    return l && (s == 6'd2 || s == 6'd3);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_en = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(posedge clk); #1;
    reg_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    for (int m = 0; m < N_MOD; m++) begin
      bus_rd(a_mstat(m), v);
      check({tag, " R8/R9 module status"}, v, f_mstat(cur_st[m]));
      check({tag, " R9 clock pin"}, 32'(mod_clk_en[m]), 32'(cur_st[m] == 6'd3));
      check({tag, " R10 reset pin"}, 32'(mod_rst_n[m]), 32'(f_rstn(cur_st[m], lrst[m])));
    end
    for (int d = 0; d < N_DOM; d++) begin
      bus_rd(a_dstat(d), v);
      check({tag, " R7/R11 domain status"}, v, 32'(on_m[d]));
      bus_rd(a_dctl(d), v);
      check({tag, " R7 power-good consumed"}, v, 32'(next_m[d]));
    end
    bus_rd(12'h070, v);
    check({tag, " R7 request idle"}, v, 32'h0);
    bus_rd(12'h128, v);
    check({tag, " R5 busy idle"}, v, 32'h0);
  endtask

  task automatic run_go(int d);
    logic [31:0] v;
    bus_wr(12'h120, 32'(1) << d);
    if (!on_m[d] && next_m[d]) begin
      idle(3);
      bus_rd(12'h070, v);
      check("R7 request raised", v, 32'(1) << d);
      check("R7 request pin", 32'(dom_pwr_req), 32'(1) << d);
      bus_rd(12'h128, v);
      check("R7 busy while waiting", v, 32'(1) << d);
      bus_wr(a_dctl(d), 32'h101);
      idle(LAT);
    end else begin
      idle(LAT - 1);
    end
    bus_rd(12'h128, v);
    check("R5 busy at last cycle", v, 32'(1) << d);
    bus_rd(12'h128, v);
    check("R5 busy cleared", v, 32'h0);
    for (int m = 0; m < N_MOD; m++) if (m % N_DOM == d) cur_st[m] = req_st[m];
    on_m[d] = next_m[d];
  endtask

  task automatic wr_mod(int m, logic [5:0] s, logic l, logic f);
    logic [31:0] v;
    bus_wr(a_mctl(m), f_mctl(s, l, f));
    req_st[m] = s; lrst[m] = l; frc[m] = f;
    bus_rd(a_mctl(m), v);
    check("R3 control readback", v, f_mctl(s, l, f));
    bus_rd(a_mstat(m), v);
    check("R4 status held without GO", v, f_mstat(cur_st[m]));
    check("R4 clock pin held", 32'(mod_clk_en[m]), 32'(cur_st[m] == 6'd3));
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int m = 0; m < N_MOD; m++) begin req_st[m] = '0; cur_st[m] = '0; lrst[m] = 1'b1; frc[m] = 1'b0; end
    for (int d = 0; d < N_DOM; d++) begin on_m[d] = 1'b0; next_m[d] = 1'b1; end
    idle(3);
    rst_n = 1'b1;
    idle(1);

    check("R1 clock pins", 32'(mod_clk_en), 32'h0);
    check("R1 reset pins", 32'(mod_rst_n), 32'h0);
    check("R1 request pins", 32'(dom_pwr_req), 32'h0);
    check_all("R1 reset");

    bus_rd(12'h004, v);            check("R12 unmapped", v, 32'h0);
    bus_rd(a_mstat(N_MOD), v);     check("R12 module slot out of range", v, 32'h0);
    bus_rd(a_dstat(N_DOM), v);     check("R12 domain slot out of range", v, 32'h0);
    bus_rd(12'h120, v);            check("R12 GO reads zero", v, 32'h0);
    bus_wr(12'h128, 32'hFFFF_FFFF);
    bus_rd(12'h128, v);            check("R12 status write ignored", v, 32'h0);
    bus_rd(12'h200, v);            check("R2 domain status offset", v, 32'h0);
    bus_rd(12'h300, v);            check("R2 domain control offset", v, 32'h1);

    // Power-up handshake on domain 0 with module 0 asked to run.
    wr_mod(0, 6'd3, 1'b1, 1'b1);
    run_go(0);
    check_all("R7 power-up");

    // Second GO while busy must not stretch the transition (R6).
    wr_mod(2, 6'd2, 1'b1, 1'b0);
    bus_wr(12'h120, 32'h1);
    bus_wr(12'h120, 32'h1);
    idle(LAT - 2);
    bus_rd(12'h128, v); check("R6 busy at last cycle", v, 32'h1);
    bus_rd(12'h128, v); check("R6 no extension", v, 32'h0);
    cur_st[2] = req_st[2];
    check_all("R6");

    // Local reset acts on the write edge, without GO (R10).
    bus_wr(a_mctl(0), f_mctl(6'd3, 1'b0, 1'b0));
    check("R10 local reset asserted", 32'(mod_rst_n[0]), 32'h0);
    check("R10 clock unaffected", 32'(mod_clk_en[0]), 32'h1);
    bus_wr(a_mctl(0), f_mctl(6'd3, 1'b1, 1'b0));
    check("R10 local reset released", 32'(mod_rst_n[0]), 32'h1);
    lrst[0] = 1'b1; frc[0] = 1'b0;

    // Power-off of domain 0 through NEXT=0 (R11).
    bus_wr(a_dctl(0), 32'h0); next_m[0] = 1'b0;
    wr_mod(0, 6'd0, 1'b1, 1'b0);
    run_go(0);
    check_all("R11 power-off");

    // Constrained random rounds.
    for (int it = 0; it < 30; it++) begin
      int d;
      d = $urandom % N_DOM;
      for (int m = 0; m < N_MOD; m++)
        if (m % N_DOM == d && ($urandom % 4) != 0)
          wr_mod(m, 6'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2));
      next_m[d] = (($urandom % 4) != 0);
      bus_wr(a_dctl(d), 32'(next_m[d]));
      run_go(d);
      check_all("R8 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule